// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a small synchronous binary counter, four bits wide by default, with a preset path. Every state bit is updated on the same rising clock edge. An active-low load input copies a data word into the counter on the next edge, whatever the count enables are doing. A direction input chooses whether the counter increments or decrements. Counting needs two active-low enables: a parallel enable that is shared across a chain, and a trickle enable that is passed from stage to stage.

The active-low terminal-count output is decoded combinationally from the state, the direction and the trickle enable. It goes low at the top of the range when counting up and at zero when counting down. Only the trickle enable qualifies it. To build a wider counter, connect each stage's terminal-count output to the next stage's trickle enable and share the parallel enable across all stages. The chain then counts synchronously with no extra gating.

A synchronous active-high reset clears the state to zero. In normal use, a parallel load sets the starting value.

Top module: `udc_stage`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros on that edge.
- R2: When `load_n` is low at a rising edge, `q` takes the value of `din` on that edge, regardless of `cnt_par_n`, `cnt_trk_n` and `up_dn`.
- R3: When `load_n` is high and either `cnt_par_n` or `cnt_trk_n` is high, `q` keeps its value across the edge.
- R4: When `load_n` is high, both enables are low and `up_dn` is 1, `q` increments by one per edge and wraps from all ones (15) to 0.
- R5: When `load_n` is high, both enables are low and `up_dn` is 0, `q` decrements by one per edge and wraps from 0 to all ones (15).
- R6: With `up_dn` = 1, `tc_n` is 0 exactly when `q` is all ones and `cnt_trk_n` is 0. Otherwise it is 1.
- R7: With `up_dn` = 0, `tc_n` is 0 exactly when `q` is zero and `cnt_trk_n` is 0. Otherwise it is 1.
- R8: `tc_n` does not depend on `cnt_par_n`, and it is 1 whenever `cnt_trk_n` is 1.
- R9: `tc_n` follows its inputs within the same cycle, with no register in its path. It leaves the terminal state as soon as `q` or `up_dn` moves away from it.
- R10: Two stages chained through `tc_n` into the next stage's `cnt_trk_n`, with `cnt_par_n` shared, count as one 8-bit counter in both directions, including wrap across 0x00/0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | W | Preset data word |
| up_dn | input | 1 | 1 = count up, 0 = count down |
| cnt_par_n | input | 1 | Active-low enable shared across a chain |
| cnt_trk_n | input | 1 | Active-low enable passed along a chain; also qualifies `tc_n` |
| q | output | W | Counter state |
| tc_n | output | 1 | Active-low terminal-count flag |

## Verification
Two functions can fall in one cycle: a parallel load and a terminal-count condition with both enables low. The bench parks the counter at its terminal value with both enables asserted, then pulls `load_n` low. It checks that `tc_n` is still low during that cycle, because the flag reflects the current state. It then checks that after the edge `q` holds the loaded word and not the wrapped count. A second collision, loading while counting down at zero, is checked in the same way.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } udc_op_e;

    typedef struct packed {
        logic load_n;
        logic up_dn;
        logic par_n;
        logic trk_n;
    } udc_ctl_t;

    function automatic udc_op_e udc_pick_op(input udc_ctl_t c);
        udc_op_e r;
        if (!c.load_n)
            r = OP_LOAD;
        else if (!c.par_n && !c.trk_n)
            r = c.up_dn ? OP_INC : OP_DEC;
        else
            r = OP_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/udc_op_dec.sv
module udc_op_dec
    import udc_pkg::*;
(
    input  udc_ctl_t ctl,
    output udc_op_e  op
);
    always_comb begin
        op = udc_pick_op(ctl);
    end
endmodule

// File: rtl/udc_next.sv
module udc_next
    import udc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] preset,
    input  udc_op_e      op,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] STEP = W'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = preset;
            OP_INC:  nxt = cur + STEP;
            OP_DEC:  nxt = cur - STEP;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/udc_tc_dec.sv
module udc_tc_dec #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         up_dn,
    input  logic         trk_n,
    output logic         tc_n
);
    logic at_top;
    logic at_bot;
    logic at_end;

    always_comb begin
        at_top = &cur;
        at_bot = ~|cur;
        at_end = up_dn ? at_top : at_bot;
        tc_n   = ~(at_end & ~trk_n);
    end
endmodule

// File: rtl/udc_stage.sv
module udc_stage
    import udc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         up_dn,
    input  logic         cnt_par_n,
    input  logic         cnt_trk_n,
    output logic [W-1:0] q,
    output logic         tc_n
);
    udc_ctl_t     ctl;
    udc_op_e      op;
    logic [W-1:0] state_r;
    logic [W-1:0] state_nxt;

    always_comb begin
        ctl.load_n = load_n;
        ctl.up_dn  = up_dn;
        ctl.par_n  = cnt_par_n;
        ctl.trk_n  = cnt_trk_n;
    end

    udc_op_dec u_op (
        .ctl (ctl),
        .op  (op)
    );

    udc_next #(.W(W)) u_nxt (
        .cur    (state_r),
        .preset (din),
        .op     (op),
        .nxt    (state_nxt)
    );

    udc_tc_dec #(.W(W)) u_tc (
        .cur   (state_r),
        .up_dn (up_dn),
        .trk_n (cnt_trk_n),
        .tc_n  (tc_n)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_r <= '0;
        else
            state_r <= state_nxt;
    end

    assign q = state_r;
endmodule

// File: rtl/udc_stage_chk.sv
module udc_stage_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         up_dn,
    input logic         cnt_par_n,
    input logic         cnt_trk_n,
    input logic [W-1:0] q,
    input logic         tc_n
);
    localparam logic [W-1:0] ONE = W'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (q == $past(din))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (load_n && (cnt_par_n || cnt_trk_n)) |=> (q == $past(q))); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_par_n && !cnt_trk_n && up_dn) |=> (q == $past(q) + ONE)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_par_n && !cnt_trk_n && !up_dn) |=> (q == $past(q) - ONE)); // R5
    AST_TC_TOP: assert property (@(posedge clk) disable iff (rst)
        (up_dn && !cnt_trk_n && (&q)) |-> !tc_n); // R6
    AST_TC_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (!up_dn && !cnt_trk_n && (q == '0)) |-> !tc_n); // R7
    AST_TC_NEEDS_TRK: assert property (@(posedge clk) disable iff (rst)
        !tc_n |-> !cnt_trk_n); // R8
endmodule

bind udc_stage udc_stage_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_n    (load_n),
    .din       (din),
    .up_dn     (up_dn),
    .cnt_par_n (cnt_par_n),
    .cnt_trk_n (cnt_trk_n),
    .q         (q),
    .tc_n      (tc_n)
);

// File: tb/udc_stage_tb.sv
module udc_stage_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic       up_dn = 1'b1;
    logic       par_n = 1'b1;
    logic       trk_n = 1'b1;
    logic [3:0] q;
    logic       tc_n;

    logic       c_load_n = 1'b1;
    logic [7:0] c_din = 8'd0;
    logic       c_up = 1'b1;
    logic       c_par_n = 1'b1;
    logic       c_trk_n = 1'b1;
    logic [3:0] lo_q, hi_q;
    logic       lo_tc, hi_tc;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    udc_stage #(.W(4)) dut_i (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din), .up_dn(up_dn),
        .cnt_par_n(par_n), .cnt_trk_n(trk_n), .q(q), .tc_n(tc_n)
    );

    udc_stage #(.W(4)) lo_i (
        .clk(clk), .rst(rst), .load_n(c_load_n), .din(c_din[3:0]), .up_dn(c_up),
        .cnt_par_n(c_par_n), .cnt_trk_n(c_trk_n), .q(lo_q), .tc_n(lo_tc)
    );

    udc_stage #(.W(4)) hi_i (
        .clk(clk), .rst(rst), .load_n(c_load_n), .din(c_din[7:4]), .up_dn(c_up),
        .cnt_par_n(c_par_n), .cnt_trk_n(lo_tc), .q(hi_q), .tc_n(hi_tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic [3:0] d, input logic ud,
                         input logic p, input logic t);
        @(negedge clk);
        load_n = ld; din = d; up_dn = ud; par_n = p; trk_n = t;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        settle();
        settle();
        chk("R1 reset value", q, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_load();
        drive(1'b0, 4'd9, 1'b1, 1'b0, 1'b0);
        settle();
        chk("R2 load with enables on", q, 9);
        drive(1'b0, 4'd3, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R2 load with enables off", q, 3);
        // collision: terminal state while loading
        drive(1'b0, 4'd15, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 4'd6, 1'b1, 1'b0, 1'b0);
        #1 chk("R6 tc low during load cycle", tc_n, 0);
        settle();
        chk("R2 load beats wrap", q, 6);
        drive(1'b0, 4'd0, 1'b0, 1'b1, 1'b1);
        drive(1'b0, 4'd11, 1'b0, 1'b0, 1'b0);
        #1 chk("R7 tc low during load cycle", tc_n, 0);
        settle();
        chk("R2 load beats down wrap", q, 11);
    endtask

    task automatic t_hold();
        drive(1'b0, 4'd5, 1'b1, 1'b1, 1'b1);
        drive(1'b1, 4'd0, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R3 hold par high", q, 5);
        drive(1'b1, 4'd0, 1'b1, 1'b0, 1'b1);
        settle();
        chk("R3 hold trk high", q, 5);
        drive(1'b1, 4'd0, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R3 hold both high", q, 5);
    endtask

    task automatic t_up();
        drive(1'b0, 4'd13, 1'b1, 1'b1, 1'b1);
        drive(1'b1, 4'd0, 1'b1, 1'b0, 1'b0);
        settle();
        chk("R4 up 13->14", q, 14);
        settle();
        chk("R4 up 14->15", q, 15);
        chk("R6 tc at 15 up", tc_n, 0);
        settle();
        chk("R4 wrap 15->0", q, 0);
        chk("R9 tc releases after wrap", tc_n, 1);
        settle();
        chk("R4 up 0->1", q, 1);
    endtask

    task automatic t_down();
        drive(1'b0, 4'd2, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 4'd0, 1'b0, 1'b0, 1'b0);
        settle();
        chk("R5 down 2->1", q, 1);
        settle();
        chk("R5 down 1->0", q, 0);
        chk("R7 tc at 0 down", tc_n, 0);
        settle();
        chk("R5 wrap 0->15", q, 15);
        chk("R7 tc high at 15 down", tc_n, 1);
        settle();
        chk("R5 down 15->14", q, 14);
    endtask

    task automatic t_tc();
        drive(1'b0, 4'd15, 1'b1, 1'b1, 1'b1);
        drive(1'b1, 4'd0, 1'b1, 1'b1, 1'b0);
        #1 chk("R8 tc low with par high", tc_n, 0);
        drive(1'b1, 4'd0, 1'b1, 1'b0, 1'b1);
        #1 chk("R8 tc high with trk high", tc_n, 1);
        drive(1'b1, 4'd0, 1'b0, 1'b1, 1'b0);
        #1 chk("R9 tc follows direction same cycle", tc_n, 1);
        drive(1'b1, 4'd0, 1'b1, 1'b1, 1'b0);
        #1 chk("R6 tc back low when up again", tc_n, 0);
        drive(1'b0, 4'd7, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R6 tc high mid range", tc_n, 1);
    endtask

    task automatic t_chain();
        logic [7:0] model;
        @(negedge clk);
        c_load_n = 1'b0; c_din = 8'hF8; c_up = 1'b1; c_par_n = 1'b1; c_trk_n = 1'b1;
        @(negedge clk);
        c_load_n = 1'b1; c_par_n = 1'b0; c_trk_n = 1'b0;
        model = 8'hF8;
        chk("R10 chain load", {hi_q, lo_q}, model);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            model = model + 8'd1;
            chk("R10 chain up", {hi_q, lo_q}, model);
        end
        c_load_n = 1'b0; c_din = 8'h05; c_up = 1'b0;
        @(negedge clk);
        c_load_n = 1'b1;
        model = 8'h05;
        chk("R10 chain load down", {hi_q, lo_q}, model);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            model = model - 8'd1;
            chk("R10 chain down", {hi_q, lo_q}, model);
        end
        c_par_n = 1'b1;
        @(negedge clk);
        chk("R10 chain hold", {hi_q, lo_q}, model);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_hold();
        t_up();
        t_down();
        t_tc();
        t_chain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule